// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

The block is a single-channel DMA mover. A host programs a source pointer, a destination pointer, a bus function code, a byte count and a control word through a small register port. Once the start bit is set, the engine reads each operand from the source into a private 16-bit holding register and then writes it to the destination. It steps the pointers and the count after each operand and stops when the count runs out or a bus cycle fails. Each operand is either one byte or one 16-bit word.

The engine pauses between operands in one of two ways. With internal pacing it issues operands back to back. With external pacing it waits for a peripheral request line before each operand. In external mode an acknowledge line marks the bus cycle that belongs to the peripheral, and a control bit picks whether that is the read or the write. A last-operand line goes with the acknowledge of the final operand.

Sticky status bits record normal completion, a failed read and a failed write. The host clears them by writing ones. An interrupt request combines these bits with two separate enables and a mask input, and goes to an external interrupt controller.

Top module: `dma_mover`

## Requirements
- R1: After reset the control word, status, count and pointers all read 0. `irq`, `bus_req` and `ext_ack` are low.
- R2: The host register map is: 0 control, 1 status, 2 function code, 3 count, 4/5 source pointer low/high, 6/7 destination pointer low/high. Every operand is read from the source pointer and then written, with the same data, to the destination pointer. A byte travels in bits 7:0 of the bus data. A word read drives `bus_fc` from function code bits 2:0, and a write drives it from bits 6:4. A bus cycle keeps its address until `bus_rdy` or `bus_err` ends it.
- R3: The control word layout is bit 14 ack side, bit 13 done-irq enable, bit 12 error-irq enable, bits 11:10 pacing, bit 9 source step, bit 8 destination step, bits 7:6 source size, bits 5:4 destination size, bits 3:2 spare, bit 1 abort, bit 0 start. A size code of 01 means byte, and any other code means word. When its step bit is 1, a pointer advances by its operand size after each completed write. When its step bit is 0, the pointer does not change.
- R4: The count falls by the source operand size on each completed write. When the count reaches 0, status bit 0 is set and the start bit is cleared. Starting with a count of 0 sets bit 0 with no bus cycle.
- R5: An error on a read sets status bit 1, clears start, and no write cycle follows.
- R6: An error on a write sets status bit 2 and clears start. The pointers and count keep their pre-operand values.
- R7: `irq` is high exactly when `irq_mask` is 1 and either status bit 0 is set with the done-irq enable, or bit 1 or bit 2 is set with the error-irq enable.
- R8: Writing status bits with 1 clears them, and bits written with 0 are kept.
- R9: With pacing bit 11 set, no operand starts until `ext_req` is high.
- R10: In external pacing, `ext_ack` marks the read cycles when the ack-side bit is 0 and the write cycles when it is 1. `ext_last` comes with the acknowledge of the final operand only.
- R11: Writing the control word with bit 1 set ends any bus cycle at the next edge, clears start and leaves the engine idle. Later requests start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register index |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for `host_addr` |
| bus_req | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_byte | output | 1 | Cycle moves one byte (else a word) |
| bus_fc | output | 3 | Function code for the cycle |
| bus_addr | output | ADDR_W | Cycle address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_rdy | input | 1 | Cycle completed |
| bus_err | input | 1 | Cycle failed |
| ext_req | input | 1 | Peripheral request |
| ext_ack | output | 1 | Peripheral acknowledge |
| ext_last | output | 1 | Final operand marker |
| irq_mask | input | 1 | Interrupt mask gate |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is an abort that lands in the middle of a bus cycle, when the engine has raised `bus_req` and is waiting on a slave that never answers. The bench's bus model has a mode in which it holds back every response. This lets the bench write the abort while the read is still pending and check that the cycle is gone at the next sample. The error cases use a one-shot fault that the bench arms for the next read or the next write. Randomized copies vary the operand size, the step bits, the operand count and the slave latency.

// File: rtl/dma_mover_pkg.sv
package dma_mover_pkg;

   localparam int HOST_W = 16;

   localparam logic [2:0] RA_CTRL   = 3'd0;
   localparam logic [2:0] RA_STAT   = 3'd1;
   localparam logic [2:0] RA_FCODE  = 3'd2;
   localparam logic [2:0] RA_COUNT  = 3'd3;
   localparam logic [2:0] RA_SRC_LO = 3'd4;
   localparam logic [2:0] RA_SRC_HI = 3'd5;
   localparam logic [2:0] RA_DST_LO = 3'd6;
   localparam logic [2:0] RA_DST_HI = 3'd7;

   typedef struct packed {
      logic       ack_wr_side;
      logic       irq_done_en;
      logic       irq_err_en;
      logic [1:0] pacing;
      logic       src_step;
      logic       dst_step;
      logic [1:0] src_sz;
      logic [1:0] dst_sz;
      logic [1:0] spare;
      logic       abort;
      logic       start;
   } ctrl_t;

   typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_READ, ST_WRITE} seq_st_t;

   function automatic logic [1:0] size_bytes(input logic [1:0] code);
      return (code == 2'b01) ? 2'd1 : 2'd2;
   endfunction

endpackage

// File: rtl/dma_mover_regs.sv
module dma_mover_regs
   import dma_mover_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [2:0]        host_addr,
   input  logic [HOST_W-1:0] host_wdata,
   output logic [HOST_W-1:0] host_rdata,
   input  logic              ev_step,
   input  logic              ev_done,
   input  logic              ev_rerr,
   input  logic              ev_werr,
   output ctrl_t             ctrl,
   output logic [7:0]        fcode,
   output logic [CNT_W-1:0]  count,
   output logic [ADDR_W-1:0] src_ptr,
   output logic [ADDR_W-1:0] dst_ptr,
   output logic [2:0]        status,
   output logic              abort,
   output logic              last_op
);
   localparam int HI_W = ADDR_W - HOST_W;

   logic [1:0] s_inc, d_inc;
   logic       wr_ctrl;

   assign s_inc   = size_bytes(ctrl.src_sz);
   assign d_inc   = size_bytes(ctrl.dst_sz);
   assign wr_ctrl = host_we && (host_addr == RA_CTRL);
   assign abort   = wr_ctrl && host_wdata[1];
   assign last_op = (count <= CNT_W'(s_inc));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl    <= '0;
         fcode   <= '0;
         count   <= '0;
         src_ptr <= '0;
         dst_ptr <= '0;
         status  <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl       <= ctrl_t'(host_wdata[14:0]);
            ctrl.abort <= 1'b0;
            if (host_wdata[1]) ctrl.start <= 1'b0;
         end
         if (ev_done || ev_rerr || ev_werr) ctrl.start <= 1'b0;
         if (host_we) begin
            case (host_addr)
               RA_FCODE:  fcode                   <= host_wdata[7:0];
               RA_COUNT:  count                   <= host_wdata[CNT_W-1:0];
               RA_SRC_LO: src_ptr[HOST_W-1:0]     <= host_wdata;
               RA_SRC_HI: src_ptr[ADDR_W-1:HOST_W] <= host_wdata[HI_W-1:0];
               RA_DST_LO: dst_ptr[HOST_W-1:0]     <= host_wdata;
               RA_DST_HI: dst_ptr[ADDR_W-1:HOST_W] <= host_wdata[HI_W-1:0];
               default: ;
            endcase
         end
         if (ev_step) begin
            if (ctrl.src_step) src_ptr <= src_ptr + ADDR_W'(s_inc);
            if (ctrl.dst_step) dst_ptr <= dst_ptr + ADDR_W'(d_inc);
            count <= last_op ? '0 : count - CNT_W'(s_inc);
         end
         status <= (status & ~((host_we && host_addr == RA_STAT) ? host_wdata[2:0] : 3'b000))
                   | {ev_werr, ev_rerr, ev_done};
      end
   end

   always_comb begin
      case (host_addr)
         RA_CTRL:   host_rdata = {1'b0, ctrl};
         RA_STAT:   host_rdata = HOST_W'(status);
         RA_FCODE:  host_rdata = HOST_W'(fcode);
         RA_COUNT:  host_rdata = HOST_W'(count);
         RA_SRC_LO: host_rdata = src_ptr[HOST_W-1:0];
         RA_SRC_HI: host_rdata = HOST_W'(src_ptr[ADDR_W-1:HOST_W]);
         RA_DST_LO: host_rdata = dst_ptr[HOST_W-1:0];
         default:   host_rdata = HOST_W'(dst_ptr[ADDR_W-1:HOST_W]);
      endcase
   end
endmodule

// File: rtl/dma_mover_seq.sv
module dma_mover_seq
   import dma_mover_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              ext_mode,
   input  logic              req_in,
   input  logic              abort,
   input  logic              count_zero,
   input  logic              last_op,
   input  logic              bus_rdy,
   input  logic              bus_err,
   input  logic [HOST_W-1:0] bus_rdata,
   output seq_st_t           state,
   output logic [HOST_W-1:0] hold,
   output logic              ev_step,
   output logic              ev_done,
   output logic              ev_rerr,
   output logic              ev_werr
);
   seq_st_t after_op;

   assign after_op = ext_mode ? ST_WAIT : ST_READ;
   assign ev_rerr  = (state == ST_READ)  && bus_err && !abort;
   assign ev_werr  = (state == ST_WRITE) && bus_err && !abort;
   assign ev_step  = (state == ST_WRITE) && bus_rdy && !bus_err && !abort;
   assign ev_done  = (ev_step && last_op) ||
                     ((state == ST_IDLE) && start && count_zero && !abort);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         hold  <= '0;
      end else if (abort) begin
         state <= ST_IDLE;
      end else begin
         case (state)
            ST_IDLE:  if (start && !count_zero) state <= after_op;
            ST_WAIT:  if (req_in) state <= ST_READ;
            ST_READ: begin
               if (bus_err) state <= ST_IDLE;
               else if (bus_rdy) begin
                  hold  <= bus_rdata;
                  state <= ST_WRITE;
               end
            end
            default: begin
               if (bus_err) state <= ST_IDLE;
               else if (bus_rdy) state <= last_op ? ST_IDLE : after_op;
            end
         endcase
      end
   end
endmodule

// File: rtl/dma_mover.sv
module dma_mover
   import dma_mover_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int CNT_W    = 16,
   parameter bit REQ_SYNC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [2:0]        host_addr,
   input  logic [15:0]       host_wdata,
   output logic [15:0]       host_rdata,
   output logic              bus_req,
   output logic              bus_we,
   output logic              bus_byte,
   output logic [2:0]        bus_fc,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [15:0]       bus_wdata,
   input  logic [15:0]       bus_rdata,
   input  logic              bus_rdy,
   input  logic              bus_err,
   input  logic              ext_req,
   output logic              ext_ack,
   output logic              ext_last,
   input  logic              irq_mask,
   output logic              irq
);
   if (ADDR_W <= HOST_W || ADDR_W > 2 * HOST_W) begin : g_bad_addr_w
      $error("dma_mover: ADDR_W must lie in 17..32");
   end
   if (CNT_W < 2 || CNT_W > HOST_W) begin : g_bad_cnt_w
      $error("dma_mover: CNT_W must lie in 2..16");
   end

   ctrl_t             ctrl;
   logic [7:0]        fcode;
   logic [CNT_W-1:0]  count;
   logic [ADDR_W-1:0] src_ptr, dst_ptr;
   logic [2:0]        status;
   logic              abort, last_op, req_in;
   logic              ev_step, ev_done, ev_rerr, ev_werr;
   seq_st_t           state;
   logic [15:0]       hold;

   if (REQ_SYNC) begin : g_req_sync
      logic [1:0] req_ff;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) req_ff <= '0;
         else        req_ff <= {req_ff[0], ext_req};
      end
      assign req_in = req_ff[1];
   end else begin : g_req_direct
      assign req_in = ext_req;
   end

   dma_mover_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .ev_step(ev_step), .ev_done(ev_done), .ev_rerr(ev_rerr), .ev_werr(ev_werr),
      .ctrl(ctrl), .fcode(fcode), .count(count), .src_ptr(src_ptr),
      .dst_ptr(dst_ptr), .status(status), .abort(abort), .last_op(last_op)
   );

   dma_mover_seq u_seq (
      .clk(clk), .rst_n(rst_n), .start(ctrl.start), .ext_mode(ctrl.pacing[1]),
      .req_in(req_in), .abort(abort), .count_zero(count == '0), .last_op(last_op),
      .bus_rdy(bus_rdy), .bus_err(bus_err), .bus_rdata(bus_rdata),
      .state(state), .hold(hold), .ev_step(ev_step), .ev_done(ev_done),
      .ev_rerr(ev_rerr), .ev_werr(ev_werr)
   );

   assign bus_req   = (state == ST_READ) || (state == ST_WRITE);
   assign bus_we    = (state == ST_WRITE);
   assign bus_byte  = bus_we ? (ctrl.dst_sz == 2'b01) : (ctrl.src_sz == 2'b01);
   assign bus_fc    = bus_we ? fcode[6:4] : fcode[2:0];
   assign bus_addr  = bus_we ? dst_ptr : src_ptr;
   assign bus_wdata = hold;
   assign ext_ack   = ctrl.pacing[1] && bus_req && (bus_we == ctrl.ack_wr_side);
   assign ext_last  = ext_ack && last_op;
   assign irq       = irq_mask && ((status[0] && ctrl.irq_done_en) ||
                                   ((status[1] || status[2]) && ctrl.irq_err_en));
endmodule

// File: rtl/dma_mover_chk.sv
module dma_mover_chk #(
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_we,
   input logic [2:0]        host_addr,
   input logic [15:0]       host_wdata,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rdy,
   input logic              bus_err,
   input logic              ext_ack,
   input logic              ext_last,
   input logic              irq_mask,
   input logic              irq
);
   logic host_abort;
   assign host_abort = host_we && (host_addr == 3'd0) && host_wdata[1];

   a_r2_cycle_held: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_rdy && !bus_err && !host_we) |=>
         (bus_req && $stable(bus_addr) && $stable(bus_we)));

   a_r5_no_write_after_rd_err: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && bus_err) |=> !bus_req);

   a_r6_stop_after_wr_err: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_err) |=> !bus_req);

   a_r7_mask_gates_irq: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_mask |-> !irq);

   a_r10_ack_inside_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      ext_ack |-> bus_req);

   a_r10_last_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
      ext_last |-> ext_ack);

   a_r11_abort_drops_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      host_abort |=> !bus_req);
endmodule

bind dma_mover dma_mover_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
   .host_wdata(host_wdata), .bus_req(bus_req), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_rdy(bus_rdy), .bus_err(bus_err),
   .ext_ack(ext_ack), .ext_last(ext_last), .irq_mask(irq_mask), .irq(irq)
);

// File: tb/dma_mover_tb_top.sv
module dma_mover_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_we = 1'b0;
   logic [2:0]    host_addr = '0;
   logic [15:0]   host_wdata = '0;
   logic [15:0]   host_rdata;
   logic          bus_req, bus_we, bus_byte, ext_ack, ext_last, irq;
   logic [2:0]    bus_fc;
   logic [AW-1:0] bus_addr;
   logic [15:0]   bus_wdata;
   logic [15:0]   bus_rdata = '0;
   logic          bus_rdy = 1'b0, bus_err = 1'b0;
   logic          ext_req = 1'b0, irq_mask = 1'b1;

   int tests = 0, fails = 0;
   logic [7:0] mem [0:255];
   logic [7:0] exp_mem [0:255];
   int  stall_max = 0, dly = 0;
   bit  hang = 0, err_rd = 0, err_wr = 0;
   int  n_rd = 0, n_wr = 0, n_ackr = 0, n_ackw = 0, n_last = 0, n_fcbad = 0;
   logic [7:0] fc_cur = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_mover dut_i (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .bus_req(bus_req),
      .bus_we(bus_we), .bus_byte(bus_byte), .bus_fc(bus_fc), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy),
      .bus_err(bus_err), .ext_req(ext_req), .ext_ack(ext_ack),
      .ext_last(ext_last), .irq_mask(irq_mask), .irq(irq)
   );

   // bus slave model: byte memory, words stored high byte first
   always @(posedge clk) begin
      bus_rdy <= 1'b0;
      bus_err <= 1'b0;
      if (rst_n && bus_req && !bus_rdy && !bus_err && !hang) begin
         if (dly != 0) dly <= dly - 1;
         else begin
            if (!bus_we && err_rd) begin bus_err <= 1'b1; err_rd <= 0; end
            else if (bus_we && err_wr) begin bus_err <= 1'b1; err_wr <= 0; end
            else begin
               bus_rdy <= 1'b1;
               if (!bus_we)
                  bus_rdata <= bus_byte ? {8'h00, mem[bus_addr[7:0]]}
                                        : {mem[bus_addr[7:0]], mem[bus_addr[7:0] + 8'd1]};
               else if (bus_byte) mem[bus_addr[7:0]] <= bus_wdata[7:0];
               else begin
                  mem[bus_addr[7:0]]        <= bus_wdata[15:8];
                  mem[bus_addr[7:0] + 8'd1] <= bus_wdata[7:0];
               end
            end
            dly <= $urandom % (stall_max + 1);
         end
      end
   end

   // running counters of completed cycles
   always @(posedge clk) begin
      if (rst_n) begin
         if (bus_req && bus_rdy) begin
            if (bus_we) n_wr++; else n_rd++;
            if (ext_ack) begin if (bus_we) n_ackw++; else n_ackr++; end
            if (ext_last) n_last++;
         end
         if (bus_req && bus_fc != (bus_we ? fc_cur[6:4] : fc_cur[2:0])) n_fcbad++;
      end
   end

   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, act=hung exp=done");
      report();
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic hwr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic hrd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      host_addr = a;
      #1 d = host_rdata;
   endtask

   function automatic logic [15:0] mk_ctrl(input bit side, input bit idone, input bit ierr,
         input logic [1:0] pace, input bit sinc, input bit dinc,
         input logic [1:0] ssz, input logic [1:0] dsz, input bit abt, input bit go);
      return {1'b0, side, idone, ierr, pace, sinc, dinc, ssz, dsz, 2'b00, abt, go};
   endfunction

   task automatic setup(input logic [AW-1:0] s, input logic [AW-1:0] d,
                        input logic [15:0] cnt, input logic [7:0] fc);
      hwr(3'd4, s[15:0]); hwr(3'd5, 16'(s[AW-1:16]));
      hwr(3'd6, d[15:0]); hwr(3'd7, 16'(d[AW-1:16]));
      hwr(3'd3, cnt); hwr(3'd2, 16'(fc));
      fc_cur = fc;
   endtask

   task automatic wait_stat(output logic [15:0] st);
      st = '0;
      for (int i = 0; i < 3000; i++) begin
         hrd(3'd1, st);
         if (st[2:0] != 0) break;
      end
   endtask

   initial begin
      logic [15:0] v, st;
      int rd0, wr0, ar0, aw0, l0;
      void'($urandom(32'h00C0FFEE));
      for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      hrd(3'd0, v); chk("R1", "ctrl", v, 0);
      hrd(3'd1, v); chk("R1", "status", v, 0);
      hrd(3'd3, v); chk("R1", "count", v, 0);
      hrd(3'd4, v); chk("R1", "src lo", v, 0);
      chk("R1", "irq", irq, 0);
      chk("R1", "bus_req", bus_req, 0);

      // R4 zero count: done with no bus cycle
      rd0 = n_rd;
      setup(24'h000010, 24'h000090, 16'd0, 8'h00);
      hwr(3'd0, mk_ctrl(0,0,0,2'b00,1,1,2'b10,2'b10,0,1));
      repeat (4) @(negedge clk);
      hrd(3'd1, v); chk("R4", "zero-count done bit", v, 16'h0001);
      chk("R4", "zero-count reads", n_rd - rd0, 0);
      hrd(3'd0, v); chk("R4", "zero-count start cleared", v[0], 0);
      hwr(3'd1, 16'h0007);

      // randomized copies: R2 R3 R4 R7
      for (int it = 0; it < 24; it++) begin
         logic [1:0] sz; int nb, nops; bit sinc, dinc;
         logic [AW-1:0] s, d; logic [7:0] fc; logic [15:0] cword;
         sz = ($urandom % 2) ? 2'b01 : 2'b10;
         nb = (sz == 2'b01) ? 1 : 2;
         nops = 1 + $urandom % 6;
         sinc = 1'($urandom); dinc = 1'($urandom);
         s = {8'($urandom), 8'h00, 8'(($urandom % 32) * 2)};
         d = {8'($urandom), 8'h00, 8'(8'h80 + ($urandom % 32) * 2)};
         fc = 8'($urandom) & 8'h77;
         stall_max = $urandom % 3;
         for (int k = 0; k < 256; k++) exp_mem[k] = mem[k];
         for (int op = 0; op < nops; op++) begin
            int sa, da;
            sa = s[7:0] + (sinc ? op * nb : 0);
            da = d[7:0] + (dinc ? op * nb : 0);
            for (int b = 0; b < nb; b++) exp_mem[(da + b) % 256] = mem[(sa + b) % 256];
         end
         rd0 = n_rd; wr0 = n_wr;
         setup(s, d, 16'(nops * nb), fc);
         cword = mk_ctrl(1'($urandom), 0, 1'($urandom), 2'b00, sinc, dinc, sz, sz, 0, 1);
         hwr(3'd0, cword);
         wait_stat(st);
         chk("R4", "done status", st, 16'h0001);
         hrd(3'd3, v); chk("R4", "count at end", v, 0);
         hrd(3'd0, v); chk("R4", "ctrl start cleared", v, {cword[15:1], 1'b0});
         hrd(3'd4, v); chk("R3", "src lo", v, 16'(s[15:0] + (sinc ? nops * nb : 0)));
         hrd(3'd7, v); chk("R3", "dst hi", v, 16'(d[23:16]));
         hrd(3'd6, v); chk("R3", "dst lo", v, 16'(d[15:0] + (dinc ? nops * nb : 0)));
         chk("R2", "read cycles", n_rd - rd0, nops);
         chk("R2", "write cycles", n_wr - wr0, nops);
         begin
            int bad = 0;
            for (int k = 128; k < 256; k++) if (mem[k] !== exp_mem[k]) bad++;
            chk("R2", "dest bytes wrong", bad, 0);
         end
         chk("R7", "irq with done-irq disabled", irq, 0);
         hwr(3'd1, 16'h0007);
      end
      chk("R2", "function code mismatches", n_fcbad, 0);
      stall_max = 1;

      // R5 read error, error irq enabled, mask gating
      wr0 = n_wr;
      setup(24'h000020, 24'h0000A0, 16'd6, 8'h21);
      err_rd = 1;
      hwr(3'd0, mk_ctrl(0,0,1,2'b00,1,1,2'b10,2'b10,0,1));
      wait_stat(st);
      chk("R5", "read error status", st, 16'h0002);
      chk("R5", "no write after read error", n_wr - wr0, 0);
      hrd(3'd0, v); chk("R5", "start cleared", v[0], 0);
      @(negedge clk); chk("R7", "irq on error with enable", irq, 1);
      irq_mask = 1'b0;
      @(negedge clk); chk("R7", "irq masked", irq, 0);
      irq_mask = 1'b1;

      // R8 write-one-to-clear
      hwr(3'd1, 16'h0005);
      hrd(3'd1, v); chk("R8", "zeros keep bit", v, 16'h0002);
      hwr(3'd1, 16'h0002);
      hrd(3'd1, v); chk("R8", "one clears bit", v, 0);
      chk("R8", "irq after clear", irq, 0);

      // R6 write error, error irq disabled
      rd0 = n_rd; wr0 = n_wr;
      setup(24'h000030, 24'h0000B0, 16'd4, 8'h00);
      err_wr = 1;
      hwr(3'd0, mk_ctrl(0,1,0,2'b00,1,1,2'b10,2'b10,0,1));
      wait_stat(st);
      chk("R6", "write error status", st, 16'h0004);
      chk("R6", "reads before stop", n_rd - rd0, 1);
      hrd(3'd3, v); chk("R6", "count kept", v, 16'd4);
      hrd(3'd6, v); chk("R6", "dst kept", v, 16'h00B0);
      chk("R7", "irq off with error enable clear", irq, 0);
      hwr(3'd1, 16'h0007);

      // R7 normal completion interrupt
      setup(24'h000040, 24'h0000C0, 16'd1, 8'h00);
      hwr(3'd0, mk_ctrl(0,1,0,2'b00,0,0,2'b01,2'b01,0,1));
      wait_stat(st);
      @(negedge clk); chk("R7", "irq on done with enable", irq, 1);
      hwr(3'd1, 16'h0007);

      // R9 R10 external pacing, ack on read side
      rd0 = n_rd; ar0 = n_ackr; aw0 = n_ackw; l0 = n_last;
      setup(24'h000000, 24'h000080, 16'd6, 8'h00);
      hwr(3'd0, mk_ctrl(0,0,0,2'b10,1,1,2'b10,2'b10,0,1));
      repeat (20) @(negedge clk);
      chk("R9", "no read before request", n_rd - rd0, 0);
      ext_req = 1'b1;
      wait_stat(st);
      chk("R9", "done after request", st, 16'h0001);
      chk("R10", "read acks side 0", n_ackr - ar0, 3);
      chk("R10", "write acks side 0", n_ackw - aw0, 0);
      chk("R10", "last pulses", n_last - l0, 1);
      hwr(3'd1, 16'h0007);

      // R10 ack on write side
      ar0 = n_ackr; aw0 = n_ackw; l0 = n_last;
      setup(24'h000000, 24'h000080, 16'd2, 8'h00);
      hwr(3'd0, mk_ctrl(1,0,0,2'b11,1,1,2'b01,2'b01,0,1));
      wait_stat(st);
      chk("R10", "read acks side 1", n_ackr - ar0, 0);
      chk("R10", "write acks side 1", n_ackw - aw0, 2);
      chk("R10", "last pulses side 1", n_last - l0, 1);
      hwr(3'd1, 16'h0007);
      ext_req = 1'b0;

      // R11 abort while waiting for request
      rd0 = n_rd;
      setup(24'h000000, 24'h000080, 16'd4, 8'h00);
      hwr(3'd0, mk_ctrl(0,0,0,2'b10,1,1,2'b10,2'b10,0,1));
      repeat (5) @(negedge clk);
      hwr(3'd0, mk_ctrl(0,0,0,2'b10,1,1,2'b10,2'b10,1,0));
      hrd(3'd0, v); chk("R11", "start and abort read 0", v[1:0], 0);
      ext_req = 1'b1;
      repeat (20) @(negedge clk);
      chk("R11", "no reads after abort", n_rd - rd0, 0);
      hrd(3'd1, v); chk("R11", "status after abort", v, 0);
      ext_req = 1'b0;

      // R11 abort during a stalled read cycle
      hang = 1;
      setup(24'h000000, 24'h000080, 16'd4, 8'h00);
      hwr(3'd0, mk_ctrl(0,0,0,2'b00,1,1,2'b10,2'b10,0,1));
      repeat (3) @(negedge clk);
      chk("R11", "read pending before abort", bus_req, 1);
      hwr(3'd0, 16'h0002);
      chk("R11", "bus_req after abort", bus_req, 0);
      hang = 0;
      repeat (10) @(negedge clk);
      chk("R11", "stays idle", bus_req, 0);

      report();
   end
endmodule